// File: doc/BRIEF.md
# SPI Display Command Decoder

This block is a receive-only SPI slave that turns three-byte command frames into write strobes for a tile-based display. It brings the serial clock, data and chip-select pins into the system clock domain through multi-stage synchronizers. It then shifts in an opcode byte and two argument bytes, most significant bit first, in SPI mode 0. Nothing is decoded while the frame is being clocked in. When chip select is released, the block checks that exactly 24 bits arrived and acts on the opcode.

A paint opcode has the binary form 10000ccc, where ccc is the colour. It issues a one-cycle write to the chunk memory. The write carries a 10-bit address, with the Y coordinate in the upper half and the X coordinate in the lower half, and the 3-bit colour. The score opcode 0x10 issues a one-cycle strobe carrying a 16-bit score built from the two argument bytes. Every other opcode, and every frame of the wrong length, leaves both outputs quiet. The block has no data output towards the master.

Top module: `spi_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it is released with no frame sent, wr_en_o and score_stb_o are 0 and wr_addr_o, wr_color_o and score_o are all zero.
- R2: The only event that dispatches a frame is the release of chip select. The resulting strobe rises on exactly the (SYNC_STAGES+1)-th rising clock edge after the chip-select pin changes to inactive, and never before.
- R3: A frame whose opcode bits [7:3] equal 5'b10000 produces one write. wr_color_o equals opcode bits [2:0], using the codes 0 black, 1 blue, 2 green, 3 cyan, 4 red, 5 purple, 6 yellow, 7 white. wr_addr_o[9:5] equals argument byte 2 (Y) and wr_addr_o[4:0] equals argument byte 1 (X). For example, opcode 0x84 with arguments 4 and 7 writes address 7*32+4 with colour 4.
- R4: Only the low five bits of each coordinate byte reach the address. Bits [7:5] of either argument byte have no effect on wr_addr_o.
- R5: A frame with opcode 0x10 produces one score strobe, with score_o[15:8] equal to argument byte 1 and score_o[7:0] equal to argument byte 2.
- R6: A frame in which the number of SCK rising edges seen while chip select was active is anything other than 24 produces no strobe of either kind.
- R7: An opcode that is neither 10000xxx nor 0x10 produces no strobe of either kind.
- R8: Each accepted frame yields exactly one strobe, one clock cycle wide, and wr_en_o and score_stb_o are never high together.
- R9: SCK and MOSI activity while chip select is inactive is ignored. It neither adds bits to the next frame nor causes a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the master (mode 0, idles low) |
| spi_mosi | input | 1 | SPI serial data from the master, MSB first |
| spi_cs | input | 1 | SPI chip select, active level set by CS_ACTIVE_LOW |
| wr_en_o | output | 1 | One-cycle chunk-memory write enable |
| wr_addr_o | output | 2*COORD_W | Chunk address {Y, X} |
| wr_color_o | output | 3 | Chunk colour code |
| score_stb_o | output | 1 | One-cycle score-valid strobe |
| score_o | output | 16 | Score value {argument 1, argument 2} |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This makes the dispatch latency of R2 depend on the parameter, so a latency that was fixed by mistake would be caught. The active-low chip select and the 5-bit coordinates stay at their defaults. That keeps the address space small enough to sweep every X and every Y value, all eight colours, and all 256 opcode bytes, each with its expected class worked out by arithmetic. Frame lengths around 24 bits and SCK activity outside a frame are also driven.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

   localparam int BYTE_W      = 8;
   localparam int FRAME_BYTES = 3;
   localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
   localparam int SCORE_W     = 2 * BYTE_W;
   localparam int COLOR_W     = 3;

   // Opcode values; paint carries the colour in its low COLOR_W bits
   localparam logic [BYTE_W-1:0] OP_PAINT = 8'h80;
   localparam logic [BYTE_W-1:0] OP_SCORE = 8'h10;

   typedef enum logic [COLOR_W-1:0] {
      COL_BLACK  = 3'd0,
      COL_BLUE   = 3'd1,
      COL_GREEN  = 3'd2,
      COL_CYAN   = 3'd3,
      COL_RED    = 3'd4,
      COL_PURPLE = 3'd5,
      COL_YELLOW = 3'd6,
      COL_WHITE  = 3'd7
   } chunk_color_e;

   typedef struct packed {
      logic [BYTE_W-1:0] op;
      logic [BYTE_W-1:0] arg_a;
      logic [BYTE_W-1:0] arg_b;
   } frame_t;

endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spicmd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= RST_VAL;
      else        stage_q[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spicmd_frame_rx.sv
module spicmd_frame_rx #(
   parameter int FRAME_BITS = 24,
   parameter int CNT_W      = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sck_s,
   input  logic                  mosi_s,
   input  logic                  sel_s,
   output logic [FRAME_BITS-1:0] frame_o,
   output logic [CNT_W-1:0]      bit_cnt_o,
   output logic                  release_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if ((1 << CNT_W) <= FRAME_BITS + 1) begin : g_bad_cnt
         $error("spicmd_frame_rx: CNT_W too narrow to tell a long frame from a full one");
      end
   endgenerate

   logic sck_q;
   logic sel_q;
   logic sck_rise;

   assign sck_rise  = sck_s & ~sck_q & sel_s;
   assign release_o = sel_q & ~sel_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         sck_q <= sck_s;
         sel_q <= sel_s;
      end
   end

   // Shift register: MSB first, the opcode ends up in the top byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_o <= '0;
      end else if (sck_rise) begin
         frame_o <= {frame_o[FRAME_BITS-2:0], mosi_s};
      end
   end

   // Saturating bit counter, cleared whenever the slave is not selected
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_o <= '0;
      end else if (!sel_s) begin
         bit_cnt_o <= '0;
      end else if (sck_rise && bit_cnt_o != CNT_MAX) begin
         bit_cnt_o <= bit_cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/spicmd_dispatch.sv
module spicmd_dispatch
   import spicmd_pkg::*;
#(
   parameter int COORD_W = 5,
   parameter int CNT_W   = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FRAME_BITS-1:0] frame_i,
   input  logic [CNT_W-1:0]      bit_cnt_i,
   input  logic                  release_i,
   output logic                  wr_en_o,
   output logic [2*COORD_W-1:0]  wr_addr_o,
   output logic [COLOR_W-1:0]    wr_color_o,
   output logic                  score_stb_o,
   output logic [SCORE_W-1:0]    score_o
);

   localparam int ADDR_W = 2 * COORD_W;

   frame_t fr;
   logic   full_frame;
   logic   is_paint;
   logic   is_score;

   assign fr         = frame_t'(frame_i);
   assign full_frame = (bit_cnt_i == CNT_W'(FRAME_BITS));
   assign is_paint   = (fr.op[BYTE_W-1:COLOR_W] == OP_PAINT[BYTE_W-1:COLOR_W]);
   assign is_score   = (fr.op == OP_SCORE);

   generate
      if (COORD_W < BYTE_W) begin : g_coord_trunc
         logic unused_coord_hi;
         assign unused_coord_hi = ^{fr.arg_a[BYTE_W-1:COORD_W], fr.arg_b[BYTE_W-1:COORD_W]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o     <= 1'b0;
         wr_addr_o   <= '0;
         wr_color_o  <= '0;
         score_stb_o <= 1'b0;
         score_o     <= '0;
      end else begin
         wr_en_o     <= 1'b0;
         score_stb_o <= 1'b0;
         if (release_i && full_frame) begin
            if (is_paint) begin
               wr_en_o    <= 1'b1;
               wr_addr_o  <= ADDR_W'({fr.arg_b[COORD_W-1:0], fr.arg_a[COORD_W-1:0]});
               wr_color_o <= fr.op[COLOR_W-1:0];
            end else if (is_score) begin
               score_stb_o <= 1'b1;
               score_o     <= {fr.arg_a, fr.arg_b};
            end
         end
      end
   end

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
   import spicmd_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int COORD_W       = 5,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sck,
   input  logic                 spi_mosi,
   input  logic                 spi_cs,
   output logic                 wr_en_o,
   output logic [2*COORD_W-1:0] wr_addr_o,
   output logic [2:0]           wr_color_o,
   output logic                 score_stb_o,
   output logic [15:0]          score_o
);

   localparam int CNT_W = $clog2(FRAME_BITS) + 1;

   generate
      if (COORD_W < 1 || COORD_W > BYTE_W) begin : g_bad_coord
         $error("spi_cmd_decoder: COORD_W must lie in 1..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_cmd_decoder: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic sel_raw;

   generate
      if (CS_ACTIVE_LOW) begin : g_cs_low
         assign sel_raw = ~spi_cs;
      end else begin : g_cs_high
         assign sel_raw = spi_cs;
      end
   endgenerate

   logic [2:0]            pins_s;
   logic [FRAME_BITS-1:0] rx_frame;
   logic [CNT_W-1:0]      rx_bit_cnt;
   logic                  frame_release;

   spicmd_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b000)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_raw, spi_mosi, spi_sck}),
      .q     (pins_s)
   );

   spicmd_frame_rx #(
      .FRAME_BITS (FRAME_BITS),
      .CNT_W      (CNT_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (pins_s[0]),
      .mosi_s    (pins_s[1]),
      .sel_s     (pins_s[2]),
      .frame_o   (rx_frame),
      .bit_cnt_o (rx_bit_cnt),
      .release_o (frame_release)
   );

   spicmd_dispatch #(
      .COORD_W (COORD_W),
      .CNT_W   (CNT_W)
   ) u_dispatch (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_i     (rx_frame),
      .bit_cnt_i   (rx_bit_cnt),
      .release_i   (frame_release),
      .wr_en_o     (wr_en_o),
      .wr_addr_o   (wr_addr_o),
      .wr_color_o  (wr_color_o),
      .score_stb_o (score_stb_o),
      .score_o     (score_o)
   );

endmodule

// File: rtl/spicmd_checker.sv
module spicmd_checker #(
   parameter int CNT_W      = 6,
   parameter int FRAME_BITS = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             score_stb,
   input logic             release_pulse,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [7:0]       op
);

   assert_write_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   assert_score_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      score_stb |=> !score_stb);

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && score_stb));

   assert_only_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || score_stb) |-> $past(release_pulse));

   assert_full_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || score_stb) |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS)));

   assert_paint_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(op[7:3]) == 5'b10000));

   assert_score_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      score_stb |-> ($past(op) == 8'h10));

endmodule

bind spi_cmd_decoder spicmd_checker #(
   .CNT_W      (CNT_W),
   .FRAME_BITS (FRAME_BITS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en_o),
   .score_stb     (score_stb_o),
   .release_pulse (frame_release),
   .bit_cnt       (rx_bit_cnt),
   .op            (rx_frame[FRAME_BITS-1 -: 8])
);

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;

   localparam int SYNC = 3;
   localparam int CW   = 5;
   localparam int H    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, mosi = 1'b0, cs = 1'b1;
   logic          wr_en, score_stb;
   logic [2*CW-1:0] wr_addr;
   logic [2:0]    wr_color;
   logic [15:0]   score;

   int checks = 0, fails = 0, cyc = 0;
   int wr_cnt = 0, sc_cnt = 0, pulse_cyc = 0, rel_cyc = 0;
   logic [2*CW-1:0] last_addr = '0;
   logic [2:0]      last_color = '0;
   logic [15:0]     last_score = '0;
   bit done = 0;

   always #4 clk = ~clk;

   spi_cmd_decoder #(.SYNC_STAGES(SYNC), .COORD_W(CW), .CS_ACTIVE_LOW(1'b1)) u_spi_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs(cs),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_color_o(wr_color),
      .score_stb_o(score_stb), .score_o(score));

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) if (rst_n) begin
      if (wr_en) begin wr_cnt++; last_addr = wr_addr; last_color = wr_color; pulse_cyc = cyc; end
      if (score_stb) begin sc_cnt++; last_score = score; pulse_cyc = cyc; end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b, input int nbits);
      logic [31:0] v;
      v = {c, a, b, 8'h00};
      cs = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = v[31-i];
         repeat (H) @(negedge clk);
         sck = 1'b1;
         repeat (H) @(negedge clk);
         sck = 1'b0;
      end
      repeat (H) @(negedge clk);
      cs = 1'b1;
      rel_cyc = cyc;
      repeat (SYNC + 6) @(negedge clk);
   endtask

   // Sends one frame and checks its outcome against the expected class
   task automatic frame(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b,
                        input int nbits, input string req);
      int w0, s0;
      bit paint, scr;
      w0 = wr_cnt; s0 = sc_cnt;
      paint = (nbits == 24) && (c[7:3] == 5'b10000);
      scr   = (nbits == 24) && (c == 8'h10);
      send(c, a, b, nbits);
      chk(wr_cnt - w0 == (paint ? 1 : 0), {req, " write count"}, wr_cnt - w0, paint ? 1 : 0);
      chk(sc_cnt - s0 == (scr ? 1 : 0), {req, " score count"}, sc_cnt - s0, scr ? 1 : 0);
      if (paint) begin
         chk(last_addr == {b[4:0], a[4:0]}, {req, " address"}, last_addr, {b[4:0], a[4:0]});
         chk(last_color == c[2:0], {req, " colour"}, last_color, c[2:0]);
      end
      if (scr) chk(last_score == {a, b}, {req, " score"}, last_score, {a, b});
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(wr_en == 0 && score_stb == 0, "R1 strobes in reset", {wr_en, score_stb}, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(wr_en == 0 && score_stb == 0 && wr_addr == 0 && wr_color == 0 && score == 0,
          "R1 idle after reset", {wr_en, score_stb, wr_addr, wr_color}, 0);

      // R3 documented example and every colour
      frame(8'h84, 8'd4, 8'd7, 24, "R3 example");
      chk(pulse_cyc - rel_cyc == SYNC + 1, "R2 dispatch latency", pulse_cyc - rel_cyc, SYNC + 1);
      for (int k = 0; k < 8; k++) frame(8'h80 | 8'(k), 8'd9, 8'd21, 24, "R3 colour sweep");
      for (int x = 0; x < 32; x++) frame(8'h82, 8'(x), 8'd13, 24, "R3 x sweep");
      for (int y = 0; y < 32; y++) frame(8'h86, 8'd17, 8'(y), 24, "R3 y sweep");

      // R4 upper coordinate bits dropped
      frame(8'h87, 8'hE3, 8'h7F, 24, "R4 high bits");
      frame(8'h81, 8'hFF, 8'hA0, 24, "R4 high bits");

      // R5 score values
      frame(8'h10, 8'h00, 8'h00, 24, "R5 zero");
      frame(8'h10, 8'hFF, 8'hFF, 24, "R5 ones");
      frame(8'h10, 8'hA5, 8'h5A, 24, "R5 pattern");
      for (int k = 0; k < 16; k++) begin
         logic [15:0] s;
         s = 16'h1 << k;
         frame(8'h10, s[15:8], s[7:0], 24, "R5 walking one");
      end
      chk(pulse_cyc - rel_cyc == SYNC + 1, "R2 score latency", pulse_cyc - rel_cyc, SYNC + 1);

      // R6 wrong lengths
      frame(8'h84, 8'd1, 8'd1, 0,  "R6 empty");
      frame(8'h84, 8'd1, 8'd1, 8,  "R6 one byte");
      frame(8'h84, 8'd1, 8'd1, 23, "R6 short");
      frame(8'h10, 8'd1, 8'd1, 25, "R6 long");
      frame(8'h84, 8'd1, 8'd1, 32, "R6 very long");

      // R7 every opcode byte
      for (int c = 0; c < 256; c++) frame(8'(c), 8'h1C, 8'h0B, 24, "R7 opcode sweep");

      // R9 bus activity while deselected
      begin
         int w0, s0;
         w0 = wr_cnt; s0 = sc_cnt;
         for (int i = 0; i < 10; i++) begin
            mosi = i[0];
            repeat (H) @(negedge clk); sck = 1'b1;
            repeat (H) @(negedge clk); sck = 1'b0;
         end
         repeat (SYNC + 6) @(negedge clk);
         chk(wr_cnt == w0 && sc_cnt == s0, "R9 idle clocks no strobe", wr_cnt - w0 + sc_cnt - s0, 0);
      end
      frame(8'h83, 8'd30, 8'd2, 24, "R9 frame after idle clocks");
      frame(8'h10, 8'h12, 8'h34, 24, "R8 single strobe");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule